// File: doc/BRIEF.md
# Datapath Scanned Through Its Own Functional Units

This block is a small register-transfer datapath. It has four 8-bit data registers, an adder, a multiplier, a two-way multiplexer and a small state counter. A single test pin turns it into its own scan structure, so no shift chain is added beside the datapath.

While scan is active, mask logic drives constant side inputs onto the arithmetic units: zero on the adder and one on the multiplier. The multiplexer select is forced toward the external input. Data then moves one register per clock along two fixed paths. One path is `din_a` → A → B → `dout_p`. The other is `din_c` → C → D → `dout_q`. Each path starts at its own input and ends at its own output, so both shift in parallel. The state counter has its own test input and its own output, so it is set and read apart from the datapath.

A built-in sequencer runs while the test pin is held high. It gives `DEPTH` scan cycles and then exactly one capture cycle, in which the datapath works normally, and it repeats this pattern. Scan-out of a response and scan-in of the next vector share the same cycles. For N vectors the total is (DEPTH+1)·N + DEPTH cycles.

Top module: `fpath_scan_top`

## Requirements
- R1: While `rst_n` is low, registers A, B, C, D and the state counter are zero and `cap_o` is 0.
- R2: On every clock that is not a scan cycle, the registers update as follows: A takes `din_a`, B takes A+D (mod 256), C takes the multiplexer output, and D takes the low 8 bits of C·B. The state counter increments modulo 4. `dout_p` shows B, `dout_q` shows D and `st_tout` shows the state counter.
- R3: The multiplexer picks `din_c` when bit 0 of the state counter is 1 and picks B when it is 0. While `test_pin` is low, `st_tin` has no effect.
- R4: In a scan cycle, the adder side input is masked to zero, so B takes A unchanged.
- R5: In a scan cycle, the multiplier side input is forced to one, so D takes C unchanged.
- R6: In a scan cycle, the multiplexer is forced to `din_c` whatever the state counter holds.
- R7: In a scan cycle, the state counter loads `st_tin`.
- R8: While `test_pin` stays high, the sequencer gives exactly DEPTH scan cycles and then one capture cycle, in which `cap_o` is 1 and the datapath acts as in R2, and repeats. Lowering `test_pin` restarts the count, so the next capture comes DEPTH cycles after the pin rises again.
- R9: In the DEPTH scan cycles after a capture, the outputs unload the captured B, D and state values while the next vector loads. N vectors take (DEPTH+1)·N + DEPTH cycles with test_pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_pin | input | 1 | Enables scan operation and the sequencer |
| din_a | input | 8 | Primary input feeding register A; start of the first scan path |
| din_c | input | 8 | Primary input at the multiplexer; start of the second scan path |
| st_tin | input | 2 | Direct test load value for the state counter |
| dout_p | output | 8 | Register B; end of the first scan path |
| dout_q | output | 8 | Register D; end of the second scan path |
| st_tout | output | 2 | State counter value |
| cap_o | output | 1 | High during the capture cycle |

## Verification
The hardest case to reach is a capture cycle that starts from register values chosen at will, followed by the unload of its response. This needs the bench to know in which cycle each loaded value lands. It needs the same for the cycle in which each captured value appears at the outputs. The bench keeps its own sequencer phase counter and its own next-state model written from the requirements. It drives whole multi-vector sessions with test_pin held high, and compares every output in every cycle. The multiplexer case is also reached by loading a state counter value with bit 0 clear during scan. Functionally that value would pick B, so the loaded C value shows whether the forced select was used.

// File: rtl/fpath_pkg.sv
package fpath_pkg;
  // Path depth of every scan path in this datapath (registers per path)
  localparam int PATH_DEPTH = 2;
  localparam int DATA_W     = 8;
  localparam int STATE_W    = 2;

  typedef enum logic [1:0] {
    PH_FUNC = 2'd0,
    PH_SCAN = 2'd1,
    PH_CAPT = 2'd2
  } phase_e;
endpackage

// File: rtl/fpath_seq.sv
module fpath_seq #(
  parameter int DEPTH = fpath_pkg::PATH_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_pin,
  output fpath_pkg::phase_e phase,
  output logic scan_mode,
  output logic cap
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LAST = CW'(DEPTH);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last   = (cnt == LAST);
  assign cap       = test_pin && at_last;
  assign scan_mode = test_pin && !at_last;

  always_comb begin
    if (!test_pin)   phase = fpath_pkg::PH_FUNC;
    else if (at_last) phase = fpath_pkg::PH_CAPT;
    else             phase = fpath_pkg::PH_SCAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!test_pin) cnt <= '0;
    else if (at_last)  cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> !cap); // R8
  AST_CAP_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> test_pin); // R8
  AST_IDLE_NO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    !test_pin |-> (!scan_mode && !cap)); // R3
  AST_CAP_TO_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && DEPTH > 0) |=> (test_pin |-> scan_mode)); // R9
endmodule

// File: rtl/fpath_streg.sv
module fpath_streg #(
  parameter int SW = fpath_pkg::STATE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan,
  input  logic [SW-1:0] tin,
  output logic [SW-1:0] q
);
  logic [SW-1:0] step_val;
  assign step_val = q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= scan ? tin : step_val;
  end

  AST_ST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    scan |=> q == $past(tin)); // R7
  AST_ST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !scan |=> q == SW'($past(q) + 1'b1)); // R2
endmodule

// File: rtl/fpath_dp.sv
module fpath_dp #(
  parameter int W = fpath_pkg::DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan,
  input  logic         sel_raw,
  input  logic [W-1:0] din_a,
  input  logic [W-1:0] din_c,
  output logic [W-1:0] rb_o,
  output logic [W-1:0] rd_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  function automatic logic [W-1:0] add_w(input logic [W-1:0] x, input logic [W-1:0] y);
    return x + y;
  endfunction

  function automatic logic [W-1:0] mul_lo(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] p;
    p = x * y;
    return p[W-1:0];
  endfunction

  logic [W-1:0] ra, rb, rc, rd;
  // Named internal events for the assertions
  logic [W-1:0] add_side, mul_side, sum_w, prod_w, mux_w;
  logic         mux_sel;

  assign add_side = scan ? ZERO : rd;   // mask to zero
  assign mul_side = scan ? ONE  : rb;   // mask to one
  assign mux_sel  = scan | sel_raw;     // forced select
  assign sum_w    = add_w(ra, add_side);
  assign prod_w   = mul_lo(rc, mul_side);
  assign mux_w    = mux_sel ? din_c : rb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra <= '0;
      rb <= '0;
      rc <= '0;
      rd <= '0;
    end else begin
      ra <= din_a;
      rb <= sum_w;
      rc <= mux_w;
      rd <= prod_w;
    end
  end

  assign rb_o = rb;
  assign rd_o = rd;

  AST_ADD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    scan |=> rb == $past(ra)); // R4
  AST_MUL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    scan |=> rd == $past(rc)); // R5
  AST_MUX_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    scan |=> rc == $past(din_c)); // R6
  AST_FUNC_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan |=> rb == W'($past(ra) + $past(rd))); // R2
  AST_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ra == $past(din_a)); // R2
endmodule

// File: rtl/fpath_scan_top.sv
module fpath_scan_top #(
  parameter int W     = fpath_pkg::DATA_W,
  parameter int SW    = fpath_pkg::STATE_W,
  parameter int DEPTH = fpath_pkg::PATH_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_pin,
  input  logic [W-1:0]  din_a,
  input  logic [W-1:0]  din_c,
  input  logic [SW-1:0] st_tin,
  output logic [W-1:0]  dout_p,
  output logic [W-1:0]  dout_q,
  output logic [SW-1:0] st_tout,
  output logic          cap_o
);
  fpath_pkg::phase_e phase;
  logic scan_mode;
  logic cap;
  logic [SW-1:0] st_q;

  fpath_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .test_pin(test_pin),
    .phase(phase), .scan_mode(scan_mode), .cap(cap)
  );

  fpath_streg #(.SW(SW)) u_st (
    .clk(clk), .rst_n(rst_n), .scan(scan_mode), .tin(st_tin), .q(st_q)
  );

  fpath_dp #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .scan(scan_mode), .sel_raw(st_q[0]),
    .din_a(din_a), .din_c(din_c), .rb_o(dout_p), .rd_o(dout_q)
  );

  assign st_tout = st_q;
  assign cap_o   = cap;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (dout_p == '0 && dout_q == '0 && st_tout == '0 && !cap_o)); // R1
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scan_mode, cap}) && ((phase == fpath_pkg::PH_CAPT) == cap)); // R8
endmodule

// File: tb/sim_fpath_scan_top.sv
module sim_fpath_scan_top;
  localparam int K = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic test_pin;
  logic [7:0] din_a, din_c;
  logic [1:0] st_tin;
  logic [7:0] dout_p, dout_q;
  logic [1:0] st_tout;
  logic cap_o;

  always #2 clk = ~clk;

  fpath_scan_top u0 (
    .clk(clk), .rst_n(rst_n), .test_pin(test_pin),
    .din_a(din_a), .din_c(din_c), .st_tin(st_tin),
    .dout_p(dout_p), .dout_q(dout_q), .st_tout(st_tout), .cap_o(cap_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench-side model
  logic [7:0] m_ra, m_rb, m_rc, m_rd;
  logic [1:0] m_st;
  int bc = 0;
  int caps = 0;
  int cycles_hi = 0;

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // One clock: drive after a falling edge, update model, check at next falling edge
  task automatic cyc(input logic tm, input logic [7:0] a, input logic [7:0] c, input logic [1:0] st);
    logic scan_b;
    logic [15:0] prod;
    logic [7:0] n_ra, n_rb, n_rc, n_rd;
    logic [1:0] n_st;
    test_pin = tm; din_a = a; din_c = c; st_tin = st;
    #1;
    chk("R8 cap_o", {15'd0, cap_o}, {15'd0, (tm && bc == K)});
    if (tm && bc == K) caps++;
    if (tm) cycles_hi++;
    scan_b = tm && (bc != K);
    if (scan_b) begin
      n_ra = a; n_rb = m_ra; n_rc = c; n_rd = m_rc; n_st = st;
    end else begin
      prod = m_rc * m_rb;
      n_ra = a; n_rb = m_ra + m_rd;
      n_rc = m_st[0] ? c : m_rb;
      n_rd = prod[7:0]; n_st = m_st + 2'd1;
    end
    m_ra = n_ra; m_rb = n_rb; m_rc = n_rc; m_rd = n_rd; m_st = n_st;
    bc = tm ? ((bc == K) ? 0 : bc + 1) : 0;
    @(negedge clk);
    if (scan_b) begin
      chk("R4 dout_p after scan", {8'd0, dout_p}, {8'd0, m_rb});
      chk("R5 dout_q after scan", {8'd0, dout_q}, {8'd0, m_rd});
      chk("R7 st_tout after scan", {14'd0, st_tout}, {14'd0, m_st});
    end else begin
      chk("R2 dout_p functional", {8'd0, dout_p}, {8'd0, m_rb});
      chk("R2 dout_q functional", {8'd0, dout_q}, {8'd0, m_rd});
      chk("R3 st_tout functional", {14'd0, st_tout}, {14'd0, m_st});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; test_pin = 1'b0; din_a = 8'h11; din_c = 8'h22; st_tin = 2'd3;
    repeat (3) @(negedge clk);
    chk("R1 dout_p reset", {8'd0, dout_p}, 16'd0);
    chk("R1 dout_q reset", {8'd0, dout_q}, 16'd0);
    chk("R1 st_tout reset", {14'd0, st_tout}, 16'd0);
    chk("R1 cap_o reset", {15'd0, cap_o}, 16'd0);
    rst_n = 1'b1;
    m_ra = 0; m_rb = 0; m_rc = 0; m_rd = 0; m_st = 0; bc = 0;
  endtask

  // R2, R3: functional operation, st_tin wiggled with no effect
  task automatic t_func();
    for (int i = 0; i < 10; i++)
      cyc(1'b0, 8'(8'h13 * i + 8'h05), 8'(8'hA7 ^ (i * 8'h1D)), 2'(i));
  endtask

  // R6: state counter loaded with bit0 clear, C still takes din_c
  task automatic t_mux_force();
    cyc(1'b0, 8'h44, 8'h00, 2'd0);
    cyc(1'b1, 8'h31, 8'h5A, 2'd0);
    cyc(1'b1, 8'h32, 8'h6B, 2'd2);
    chk("R6 D holds forced mux value", {8'd0, dout_q}, 16'h005A);
    chk("R6 B holds first scan value", {8'd0, dout_p}, 16'h0031);
    cyc(1'b0, 8'h00, 8'h00, 2'd1);
  endtask

  // R8: capture spacing and restart when the pin drops
  task automatic t_seq();
    int c0;
    c0 = caps;
    for (int i = 0; i < 7; i++) cyc(1'b1, 8'(i + 1), 8'(8'hF0 - i), 2'(i));
    chk("R8 capture count over 7 cycles", 16'(caps - c0), 16'd2);
    cyc(1'b0, 8'h09, 8'h0A, 2'd1);
    c0 = caps;
    cyc(1'b1, 8'h01, 8'h02, 2'd3);
    chk("R8 no capture right after restart", 16'(caps - c0), 16'd0);
    cyc(1'b1, 8'h03, 8'h04, 2'd1);
    cyc(1'b1, 8'h05, 8'h06, 2'd2);
    chk("R8 capture after DEPTH scans", 16'(caps - c0), 16'd1);
    cyc(1'b0, 8'h00, 8'h00, 2'd0);
  endtask

  // R9: N vectors, overlapped unload/load, total cycle budget
  task automatic t_session(input int n);
    int c0;
    c0 = caps; cycles_hi = 0;
    for (int v = 0; v < n; v++) begin
      cyc(1'b1, 8'(8'h81 + 7 * v), 8'(8'h17 * (v + 3)), 2'(v));
      cyc(1'b1, 8'(8'h29 + 5 * v), 8'(8'hC3 - 9 * v), 2'(v + 1));
      cyc(1'b1, 8'(8'h6E ^ v), 8'(8'h3C + v), 2'(v + 2));
    end
    cyc(1'b1, 8'h00, 8'h00, 2'd0);
    cyc(1'b1, 8'h00, 8'h00, 2'd0);
    chk("R9 capture count", 16'(caps - c0), 16'(n));
    chk("R9 session length", 16'(cycles_hi), 16'((K + 1) * n + K));
    cyc(1'b0, 8'h00, 8'h00, 2'd0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_func();
    t_mux_force();
    t_seq();
    t_session(3);
    t_session(5);
    t_func();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule